// File: doc/BRIEF.md
# Sequential Shift and Rotate Unit with Condition Flags

This unit carries out a single shift or rotate on a byte, word or long slice of a 32-bit operand, moving the value one bit position per clock. Eight operations are available. There are arithmetic and logical shifts in both directions, plain rotates in both directions, and rotates in both directions that pass through an extend bit. The unit also produces the five condition flags that follow from the operation: extend, negative, zero, overflow and carry.

The bit count has three sources. It can be a 3-bit immediate field, a register value reduced modulo 64, or a fixed single-bit count for the memory-operand word form. A start pulse captures every input. The unit then stays busy for a latency that depends on the count and the size. At the end it raises `done` for one clock, and the merged result and flags are valid in that cycle. They stay unchanged until the next start.

Only the sized low slice is rewritten. The bits above it leave the unit as they came in. A surrounding execution core can therefore write the full 32-bit value back as it is.

Top module: `shift_rotate_unit`

## Requirements
- R1: While idle, a start pulse captures all inputs and raises `busy`. `busy` stays high until the cycle in which `done` is high and is low in the following cycle. A start seen while `busy` is high has no effect on the running operation or on its result.
- R2: The operation count is chosen as follows:
  - With `mem_form`=1, the unit works on a word (`size` is ignored) and the count is exactly 1.
  - Otherwise, with `cnt_from_reg`=1, the count is `cnt_reg` modulo 64.
  - Otherwise, the count is `cnt_imm`, where a value of 0 stands for 8.
- R3: Let n be the count. Latency L is 6+2n for byte and word, and 8+2n for long. `size` encodes 0=byte, 1=word, 2 or 3=long. Counting the start cycle as cycle 1, `done` is high for one clock in cycle L.
- R4: `result` bits above the operand size equal the captured operand bits. Only bits [7:0] (byte) or [15:0] (word) can differ.
- R5: `flags_out` holds {X,N,Z,V,C} in bits [4:0]. N is the top bit of the sized result. Z is 1 exactly when the sized result is zero.
- R6: With a count of zero, the sized value is unchanged, V=0, X keeps the captured `x_in`, and N and Z reflect the operand. C=0 except in the rotate-through-extend case, where C=X.
- R7: For op 0 (arithmetic left), V=1 if the top bit of the sized value changes at any single step. For every other op, V=0.
- R8: Shift ops are 0 arithmetic left, 1 arithmetic right, 2 logical left and 3 logical right. With a nonzero count, C and X both equal the last bit shifted out. A count at or above the width gives zero for ops 0, 2 and 3, and gives copies of the sign bit for op 1.
- R9: Ops 4 (rotate left) and 5 (rotate right) leave X equal to `x_in` and set C to the last bit rotated out.
- R10: Ops 6 (left) and 7 (right) rotate a ring made of the sized value plus X, with `x_in` as the starting X. At the end, C equals X, and both equal the last bit moved out. A count equal to width+1 returns the operand unchanged, with C=X=`x_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Capture inputs and begin (ignored while busy) |
| op | input | 3 | Operation code, see R8 to R10 |
| size | input | 2 | 0 byte, 1 word, 2/3 long |
| mem_form | input | 1 | Single-bit word form |
| cnt_from_reg | input | 1 | Take count from `cnt_reg` instead of `cnt_imm` |
| cnt_imm | input | 3 | Immediate count, 0 means 8 |
| cnt_reg | input | 32 | Register count value, used modulo 64 |
| operand | input | 32 | Value to shift or rotate |
| x_in | input | 1 | Incoming extend flag |
| result | output | 32 | Merged result, valid from `done` |
| flags_out | output | 5 | {X,N,Z,V,C}, valid from `done` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench builds the unit with its default parameters: 6 count bits, bases of 6 and 8 cycles, and 2 cycles per step. With these values every register count from 0 to 63 can be reached. That range covers counts that stop short of the width, counts that equal it, counts that exceed it, and the width+1 ring identity of the extend rotates. It also exercises latencies up to 134 cycles. Directed cases pin the zero count, the immediate value 0 standing for 8, large register values that wrap modulo 64, and the memory form. Random cases mix all eight operations over all three sizes.

// File: rtl/srt_pkg.sv
package srt_pkg;

  typedef enum logic [2:0] {
    OP_SAL = 3'd0,
    OP_SAR = 3'd1,
    OP_SLL = 3'd2,
    OP_SLR = 3'd3,
    OP_RL  = 3'd4,
    OP_RR  = 3'd5,
    OP_RXL = 3'd6,
    OP_RXR = 3'd7
  } srt_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } srt_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;

  localparam int FLG_X = 4;
  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_V = 1;
  localparam int FLG_C = 0;

endpackage

// File: rtl/srt_rst_sync.sv
module srt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_ns <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_ns <= meta_q;
    end
  end
endmodule

// File: rtl/srt_count_decode.sv
module srt_count_decode
  import srt_pkg::*;
#(
  parameter int CNT_BITS   = 6,
  parameter int BASE_SHORT = 6,
  parameter int BASE_LONG  = 8,
  parameter int STEP_CYC   = 2,
  parameter int STEP_W     = 7,
  parameter int LAT_W      = 8
) (
  input  logic              mem_i,
  input  logic              from_reg_i,
  input  logic [2:0]        imm_i,
  input  logic [31:0]       reg_i,
  input  logic [1:0]        size_i,
  output logic [STEP_W-1:0] steps_o,
  output logic [1:0]        size_o,
  output logic [LAT_W-1:0]  lat_o
);
  localparam logic [31:0] CNT_MOD = 32'd1 << CNT_BITS;

  logic [31:0] reg_mod;
  int          base_cyc;

  always_comb begin
    reg_mod = reg_i % CNT_MOD;
    if (mem_i) begin
      steps_o = STEP_W'(1);
    end else if (from_reg_i) begin
      steps_o = STEP_W'(reg_mod);
    end else if (imm_i == 3'd0) begin
      steps_o = STEP_W'(8);
    end else begin
      steps_o = STEP_W'(imm_i);
    end
    size_o   = mem_i ? SZ_WORD : size_i;
    base_cyc = (size_o[1]) ? BASE_LONG : BASE_SHORT;
    lat_o    = LAT_W'(base_cyc + STEP_CYC * int'(steps_o));
  end
endmodule

// File: rtl/srt_step_engine.sv
module srt_step_engine
  import srt_pkg::*;
(
  input  srt_op_e     op_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] work_i,
  input  logic        x_i,
  output logic [31:0] work_o,
  output logic        out_o,
  output logic        vstep_o
);
  for (genvar g = 0; g < 3; g++) begin : g_lane
    localparam int W = 8 << g;
    logic [W-1:0] s;
    logic [W-1:0] r;
    logic         o;
    logic         v;
    logic [31:0]  full;

    assign s = work_i[W-1:0];

    always_comb begin
      r = s;
      o = 1'b0;
      v = 1'b0;
      case (op_i)
        OP_SAL: begin o = s[W-1]; r = {s[W-2:0], 1'b0};   v = s[W-1] ^ s[W-2]; end
        OP_SAR: begin o = s[0];   r = {s[W-1], s[W-1:1]}; end
        OP_SLL: begin o = s[W-1]; r = {s[W-2:0], 1'b0};   end
        OP_SLR: begin o = s[0];   r = {1'b0, s[W-1:1]};   end
        OP_RL:  begin o = s[W-1]; r = {s[W-2:0], s[W-1]}; end
        OP_RR:  begin o = s[0];   r = {s[0], s[W-1:1]};   end
        OP_RXL: begin o = s[W-1]; r = {s[W-2:0], x_i};    end
        OP_RXR: begin o = s[0];   r = {x_i, s[W-1:1]};    end
        default: begin r = s; end
      endcase
    end

    if (W < 32) begin : g_part
      assign full = {work_i[31:W], r};
    end else begin : g_whole
      assign full = r;
    end
  end

  always_comb begin
    case (size_i)
      2'd0: begin work_o = g_lane[0].full; out_o = g_lane[0].o; vstep_o = g_lane[0].v; end
      2'd1: begin work_o = g_lane[1].full; out_o = g_lane[1].o; vstep_o = g_lane[1].v; end
      default: begin work_o = g_lane[2].full; out_o = g_lane[2].o; vstep_o = g_lane[2].v; end
    endcase
  end
endmodule

// File: rtl/srt_flag_gen.sv
module srt_flag_gen
  import srt_pkg::*;
(
  input  logic [31:0] work_i,
  input  logic [1:0]  size_i,
  input  logic        x_i,
  input  logic        c_i,
  input  logic        v_i,
  output logic [4:0]  flags_o
);
  logic neg;
  logic zer;

  always_comb begin
    case (size_i)
      2'd0:    begin neg = work_i[7];  zer = (work_i[7:0]  == 8'd0);  end
      2'd1:    begin neg = work_i[15]; zer = (work_i[15:0] == 16'd0); end
      default: begin neg = work_i[31]; zer = (work_i == 32'd0);       end
    endcase
    flags_o        = '0;
    flags_o[FLG_X] = x_i;
    flags_o[FLG_N] = neg;
    flags_o[FLG_Z] = zer;
    flags_o[FLG_V] = v_i;
    flags_o[FLG_C] = c_i;
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import srt_pkg::*;
#(
  parameter int CNT_BITS   = 6,
  parameter int BASE_SHORT = 6,
  parameter int BASE_LONG  = 8,
  parameter int STEP_CYC   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  op,
  input  logic [1:0]  size,
  input  logic        mem_form,
  input  logic        cnt_from_reg,
  input  logic [2:0]  cnt_imm,
  input  logic [31:0] cnt_reg,
  input  logic [31:0] operand,
  input  logic        x_in,
  output logic [31:0] result,
  output logic [4:0]  flags_out,
  output logic        busy,
  output logic        done
);
  localparam int REG_MAX   = (1 << CNT_BITS) - 1;
  localparam int MAX_STEPS = (REG_MAX > 8) ? REG_MAX : 8;
  localparam int STEP_W    = $clog2(MAX_STEPS + 1);
  localparam int MAX_LAT   = BASE_LONG + STEP_CYC * MAX_STEPS;
  localparam int LAT_W     = $clog2(MAX_LAT + 1);

  logic rst_ns;

  srt_state_e        state_q, state_d;
  logic [31:0]       work_q, work_d;
  logic              x_q, x_d;
  logic              c_q, c_d;
  logic              v_q, v_d;
  logic [STEP_W-1:0] steps_q, steps_d;
  logic [LAT_W-1:0]  cyc_q, cyc_d;
  srt_op_e           op_q;
  logic [1:0]        size_q;

  logic              ld_en, step_en, data_en, cyc_en;
  logic [STEP_W-1:0] dec_steps;
  logic [1:0]        dec_size;
  logic [LAT_W-1:0]  dec_lat;
  logic [31:0]       eng_work;
  logic              eng_out, eng_v;
  srt_op_e           op_in;
  logic              rot_plain;

  srt_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  srt_count_decode #(
    .CNT_BITS   (CNT_BITS),
    .BASE_SHORT (BASE_SHORT),
    .BASE_LONG  (BASE_LONG),
    .STEP_CYC   (STEP_CYC),
    .STEP_W     (STEP_W),
    .LAT_W      (LAT_W)
  ) u_dec (
    .mem_i      (mem_form),
    .from_reg_i (cnt_from_reg),
    .imm_i      (cnt_imm),
    .reg_i      (cnt_reg),
    .size_i     (size),
    .steps_o    (dec_steps),
    .size_o     (dec_size),
    .lat_o      (dec_lat)
  );

  srt_step_engine u_eng (
    .op_i    (op_q),
    .size_i  (size_q),
    .work_i  (work_q),
    .x_i     (x_q),
    .work_o  (eng_work),
    .out_o   (eng_out),
    .vstep_o (eng_v)
  );

  srt_flag_gen u_flg (
    .work_i  (work_q),
    .size_i  (size_q),
    .x_i     (x_q),
    .c_i     (c_q),
    .v_i     (v_q),
    .flags_o (flags_out)
  );

  assign op_in     = srt_op_e'(op);
  assign rot_plain = (op_q == OP_RL) || (op_q == OP_RR);

  // next-state logic
  always_comb begin
    ld_en   = (state_q == ST_IDLE) && start;
    step_en = (state_q == ST_RUN) && (steps_q != '0);
    data_en = ld_en || step_en;
    cyc_en  = ld_en || (state_q == ST_RUN);

    state_d = state_q;
    work_d  = work_q;
    x_d     = x_q;
    c_d     = c_q;
    v_d     = v_q;
    steps_d = steps_q;
    cyc_d   = cyc_q;

    if (ld_en) begin
      state_d = ST_RUN;
      work_d  = operand;
      x_d     = x_in;
      c_d     = (op_in == OP_RXL || op_in == OP_RXR) ? x_in : 1'b0;
      v_d     = 1'b0;
      steps_d = dec_steps;
      cyc_d   = dec_lat - LAT_W'(1);
    end else if (state_q == ST_RUN) begin
      if (cyc_q == '0) begin
        state_d = ST_IDLE;
      end else begin
        cyc_d = cyc_q - LAT_W'(1);
      end
      if (step_en) begin
        work_d  = eng_work;
        c_d     = eng_out;
        v_d     = v_q | eng_v;
        x_d     = rot_plain ? x_q : eng_out;
        steps_d = steps_q - STEP_W'(1);
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      work_q  <= '0;
      x_q     <= 1'b0;
      c_q     <= 1'b0;
      v_q     <= 1'b0;
      steps_q <= '0;
      cyc_q   <= '0;
      op_q    <= OP_SAL;
      size_q  <= SZ_BYTE;
    end else begin
      state_q <= state_d;
      if (data_en) begin
        work_q  <= work_d;
        x_q     <= x_d;
        c_q     <= c_d;
        v_q     <= v_d;
        steps_q <= steps_d;
      end
      if (cyc_en) begin
        cyc_q <= cyc_d;
      end
      if (ld_en) begin
        op_q   <= op_in;
        size_q <= dec_size;
      end
    end
  end

  assign result = work_q;
  assign busy   = (state_q == ST_RUN);
  assign done   = (state_q == ST_RUN) && (cyc_q == '0);

endmodule

// File: rtl/shift_rotate_unit_chk.sv
module shift_rotate_unit_chk #(
  parameter int CNT_BITS   = 6,
  parameter int BASE_SHORT = 6,
  parameter int BASE_LONG  = 8,
  parameter int STEP_CYC   = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [2:0]  op,
  input logic [1:0]  size,
  input logic        mem_form,
  input logic        cnt_from_reg,
  input logic [2:0]  cnt_imm,
  input logic [31:0] cnt_reg,
  input logic [31:0] operand,
  input logic        x_in,
  input logic [31:0] result,
  input logic [4:0]  flags_out
);
  logic [2:0]  op_l;
  logic [1:0]  size_l;
  logic [31:0] operand_l;
  logic        x_l;
  logic [8:0]  lat_l;
  logic [8:0]  cnt_q;
  int          n_e;
  logic [1:0]  sz_e;
  int          lat_e;
  logic        accept;

  always_comb begin
    accept = start && !busy;
    if (mem_form)          n_e = 1;
    else if (cnt_from_reg) n_e = int'(cnt_reg % (32'd1 << CNT_BITS));
    else if (cnt_imm == 0) n_e = 8;
    else                   n_e = int'(cnt_imm);
    sz_e  = mem_form ? 2'd1 : size;
    lat_e = (sz_e[1] ? BASE_LONG : BASE_SHORT) + STEP_CYC * n_e;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_l      <= '0;
      size_l    <= '0;
      operand_l <= '0;
      x_l       <= 1'b0;
      lat_l     <= '0;
      cnt_q     <= '0;
    end else if (accept) begin
      op_l      <= op;
      size_l    <= sz_e;
      operand_l <= operand;
      x_l       <= x_in;
      lat_l     <= 9'(lat_e);
      cnt_q     <= 9'd1;
    end else if (busy) begin
      cnt_q <= cnt_q + 9'd1;
    end
  end

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt_q == lat_l));
  assert_single_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_hold_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_upper_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && size_l == 2'd0) |-> (result[31:8] == operand_l[31:8]));
  assert_upper_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && size_l == 2'd1) |-> (result[31:16] == operand_l[31:16]));
  assert_zero_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && size_l == 2'd0) |-> (flags_out[2] == (result[7:0] == 8'd0)));
  assert_v_only_sal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_l != 3'd0) |-> !flags_out[1]);
  assert_rot_keep_x_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_l == 3'd4 || op_l == 3'd5)) |-> (flags_out[4] == x_l));
  assert_ring_c_eq_x_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_l[2:1] == 2'b11) |-> (flags_out[0] == flags_out[4]));

endmodule

bind shift_rotate_unit shift_rotate_unit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_ns),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .op           (op),
  .size         (size),
  .mem_form     (mem_form),
  .cnt_from_reg (cnt_from_reg),
  .cnt_imm      (cnt_imm),
  .cnt_reg      (cnt_reg),
  .operand      (operand),
  .x_in         (x_in),
  .result       (result),
  .flags_out    (flags_out)
);

// File: tb/shift_rotate_unit_tb.sv
`timescale 1ns/1ps
module shift_rotate_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  op;
  logic [1:0]  size;
  logic        mem_form;
  logic        cnt_from_reg;
  logic [2:0]  cnt_imm;
  logic [31:0] cnt_reg;
  logic [31:0] operand;
  logic        x_in;
  logic [31:0] result;
  logic [4:0]  flags_out;
  logic        busy;
  logic        done;

  int checks = 0;
  int errors = 0;
  logic [31:0] last_res;
  logic [4:0]  last_flg;
  int          last_lat;

  always #2.5 clk = ~clk;

  shift_rotate_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .size(size),
    .mem_form(mem_form), .cnt_from_reg(cnt_from_reg), .cnt_imm(cnt_imm),
    .cnt_reg(cnt_reg), .operand(operand), .x_in(x_in), .result(result),
    .flags_out(flags_out), .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirements: flags {X,N,Z,V,C}
  function automatic void model(input logic [2:0] o, input logic [1:0] sz, input logic mf,
                                input logic fr, input logic [2:0] im, input logic [31:0] cr,
                                input logic [31:0] d, input logic xi,
                                output logic [31:0] r, output logic [4:0] f, output int lat);
    int w, n;
    logic [31:0] mask, top, v;
    logic x, c, vv, msb, lsb, ob;
    w = mf ? 16 : (sz == 2'd0 ? 8 : (sz == 2'd1 ? 16 : 32));
    n = mf ? 1 : (fr ? int'(cr % 64) : (im == 0 ? 8 : int'(im)));
    mask = (w == 32) ? 32'hffff_ffff : ((32'd1 << w) - 32'd1);
    top  = 32'd1 << (w - 1);
    v = d & mask;
    x = xi;
    c = (o >= 3'd6) ? xi : 1'b0;
    vv = 1'b0;
    for (int i = 0; i < n; i++) begin
      msb = ((v & top) != 0);
      lsb = v[0];
      case (o)
        3'd0: begin ob = msb; v = (v << 1) & mask; if (((v & top) != 0) != msb) vv = 1'b1; end
        3'd1: begin ob = lsb; v = (v >> 1) | (msb ? top : 32'd0); end
        3'd2: begin ob = msb; v = (v << 1) & mask; end
        3'd3: begin ob = lsb; v = v >> 1; end
        3'd4: begin ob = msb; v = ((v << 1) | {31'd0, msb}) & mask; end
        3'd5: begin ob = lsb; v = (v >> 1) | (lsb ? top : 32'd0); end
        3'd6: begin ob = msb; v = ((v << 1) | {31'd0, x}) & mask; x = ob; end
        default: begin ob = lsb; v = (v >> 1) | (x ? top : 32'd0); x = ob; end
      endcase
      c = ob;
      if (o < 3'd4) x = ob;
    end
    r = (d & ~mask) | v;
    f = {x, ((v & top) != 0), (v == 32'd0), vv, c};
    lat = (w == 32 ? 8 : 6) + 2 * n;
  endfunction

  task automatic run_op(input string tag, input logic [2:0] o, input logic [1:0] sz,
                        input logic mf, input logic fr, input logic [2:0] im,
                        input logic [31:0] cr, input logic [31:0] d, input logic xi,
                        input bit poke);
    logic [31:0] er;
    logic [4:0]  ef;
    int          el;
    int          cyc;
    model(o, sz, mf, fr, im, cr, d, xi, er, ef, el);
    @(negedge clk);
    op = o; size = sz; mem_form = mf; cnt_from_reg = fr; cnt_imm = im;
    cnt_reg = cr; operand = d; x_in = xi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    operand = ~d; x_in = ~xi; cnt_reg = cr + 32'd7;
    cyc = 1;
    while (!done && cyc < 300) begin
      if (poke && cyc == 2) begin
        start = 1'b1; op = o + 3'd1; size = sz + 2'd1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk({tag, " R3 latency"}, 32'(cyc), 32'(el));
    chk({tag, " R4 result"}, result, er);
    chk({tag, " R5 flags"}, {27'd0, flags_out}, {27'd0, ef});
    last_res = result; last_flg = flags_out; last_lat = cyc;
    @(negedge clk);
    chk({tag, " R1 busy released"}, {31'd0, busy}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; op = '0; size = '0; mem_form = 1'b0;
    cnt_from_reg = 1'b0; cnt_imm = '0; cnt_reg = '0; operand = '0; x_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", {31'd0, busy}, 32'd0);
    chk("R1 reset done", {31'd0, done}, 32'd0);
    chk("R1 reset result", result, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed cases with fixed expectations
    run_op("R7 sal byte 2", 3'd0, 2'd0, 1'b0, 1'b1, 3'd0, 32'd2, 32'hce3dd567, 1'b0, 1'b0);
    chk("R7 sal byte value", last_res, 32'hce3dd59c);
    chk("R7 sal byte flags", {27'd0, last_flg}, {27'd0, 5'b11011});
    run_op("R2 sal byte 105", 3'd0, 2'd0, 1'b0, 1'b1, 3'd0, 32'd105, 32'hce3dd567, 1'b0, 1'b0);
    chk("R2 modulo latency", 32'(last_lat), 32'd88);
    chk("R8 sal zero fill", last_res, 32'hce3dd500);
    run_op("R8 sar long 32", 3'd1, 2'd2, 1'b0, 1'b1, 3'd0, 32'd32, 32'hce3dd567, 1'b0, 1'b0);
    chk("R8 sar sign fill", last_res, 32'hffffffff);
    chk("R8 sar flags", {27'd0, last_flg}, {27'd0, 5'b11001});
    run_op("R2 sll imm 0", 3'd2, 2'd2, 1'b0, 1'b0, 3'd0, 32'd0, 32'hce3dd567, 1'b0, 1'b0);
    chk("R2 imm zero is eight", last_res, 32'h3dd56700);
    run_op("R6 rl zero", 3'd4, 2'd1, 1'b0, 1'b1, 3'd0, 32'd64, 32'hce3dd567, 1'b1, 1'b0);
    chk("R6 zero flags", {27'd0, last_flg}, {27'd0, 5'b11000});
    chk("R6 zero latency", 32'(last_lat), 32'd6);
    run_op("R6 rxl zero", 3'd6, 2'd0, 1'b0, 1'b1, 3'd0, 32'd0, 32'h00000080, 1'b1, 1'b0);
    run_op("R6 sll zero", 3'd2, 2'd2, 1'b0, 1'b1, 3'd0, 32'd0, 32'h00000000, 1'b1, 1'b0);
    run_op("R10 rxl ring 9", 3'd6, 2'd0, 1'b0, 1'b1, 3'd0, 32'd9, 32'hce3dd567, 1'b1, 1'b0);
    chk("R10 ring identity", last_res, 32'hce3dd567);
    chk("R10 ring flags", {27'd0, last_flg}, {27'd0, 5'b10001});
    run_op("R9 rr long 26", 3'd5, 2'd2, 1'b0, 1'b1, 3'd0, 32'd26, 32'hce3dd599, 1'b0, 1'b0);
    chk("R9 rr value", last_res, 32'h8f756673);
    run_op("R2 mem rxl", 3'd6, 2'd2, 1'b1, 1'b1, 3'd5, 32'd40, 32'h1234d567, 1'b0, 1'b0);
    chk("R2 mem value", last_res, 32'h1234aace);
    chk("R2 mem latency", 32'(last_lat), 32'd8);
    run_op("R1 start while busy", 3'd7, 2'd1, 1'b0, 1'b1, 3'd0, 32'd22, 32'hce3dd567, 1'b1, 1'b1);
    run_op("R10 rxr word 17", 3'd7, 2'd1, 1'b0, 1'b1, 3'd0, 32'd17, 32'h5555d567, 1'b0, 1'b0);
    run_op("R8 slr byte 8", 3'd3, 2'd0, 1'b0, 1'b0, 3'd0, 32'd0, 32'h000000ff, 1'b0, 1'b0);

    // constrained random
    for (int k = 0; k < 300; k++) begin
      logic [2:0] ro;
      logic [1:0] rs;
      ro = 3'($urandom % 8);
      rs = 2'($urandom % 3);
      run_op((ro < 3'd4) ? "R8 rand shift" : ((ro < 3'd6) ? "R9 rand rot" : "R10 rand ring"),
             ro, rs, ($urandom % 8) == 0, 1'($urandom), 3'($urandom), $urandom,
             $urandom, 1'($urandom), ($urandom % 16) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule